// File: doc/BRIEF.md
# Load/Store-Multiple Sequencer

This block carries out single-word loads and stores, and block transfers of several registers, on a memory bus that is shared with instruction fetch. The pipeline hands it a decoded request: direction, base byte address, and either one register number or an 8-bit register bitmap. The sequencer then moves one word per cycle between the register file and consecutive memory words. While it works it reports busy and holds the fetch path off the bus. A one-cycle done pulse tells the pipeline that the transfer has finished.

The controller has three states. ST_IDLE waits for a request. ST_SETUP is the one cycle in which the instruction is decoded and the bus stays free. ST_XFER performs one word access per cycle. The transitions are as follows. IDLE moves to SETUP when a request is accepted. SETUP moves to XFER when the captured list is non-empty and back to IDLE when it is empty. XFER stays in XFER while registers remain and returns to IDLE after the last one. Memory read data and register read data are both taken combinationally in the access cycle.

Top module: `lsm_sequencer`

## Requirements
- R1: After reset, busy, done, fetch_stall, mem_en, mem_we and rf_we are all low.
- R2: A request with req_multi=1 that is accepted while idle keeps busy high for exactly 1+N cycles, where N is the number of set bits in the 8-bit req_list. Bit i of req_list selects register i.
- R3: A request with req_multi=0 transfers only register req_reg, ignores req_list, and keeps busy high for exactly 2 cycles.
- R4: The first busy cycle has no bus access. Access k (k=0,1,…) happens in busy cycle k+2 at byte address base+4k, with one access per cycle.
- R5: Registers are transferred in ascending register number. The lowest-numbered selected register goes with the lowest address.
- R6: A load (req_store=0) writes each accessed memory word into its register, with rf_we=1 in the access cycle.
- R7: A store (req_store=1) writes each register's value to its memory word, with mem_we=1 in the access cycle.
- R8: fetch_stall is high in exactly the cycles in which busy is high.
- R9: An empty list in multiple mode completes in one busy cycle with no bus access and no register write.
- R10: done is high for exactly one cycle, namely the first cycle after the last busy cycle.
- R11: req_valid is ignored while busy. Such a request starts no transfer and touches no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_multi | input | 1 | 1 = use register bitmap, 0 = single register |
| req_base | input | ADDR_W | Base byte address |
| req_list | input | NREG | Register bitmap, bit i = register i |
| req_reg | input | IDX_W | Register number for single transfers |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fetch_stall | output | 1 | Blocks instruction fetch on the shared bus |
| mem_en | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Bus write |
| mem_addr | output | ADDR_W | Bus byte address |
| mem_wdata | output | DATA_W | Bus write data |
| mem_rdata | input | DATA_W | Bus read data (same cycle) |
| rf_raddr | output | IDX_W | Register file read index |
| rf_rdata | input | DATA_W | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | IDX_W | Register file write index |
| rf_wdata | output | DATA_W | Register file write data |

## Verification
The bench targets the following corner cases:
- A full bitmap and a sparse bitmap. A walker that skipped a bit or visited one twice would miscount the 1+N cycles or misplace a word.
- Lists whose only member is register 0 or register 7. An off-by-one in the priority pick would show up here as the wrong register.
- Single mode with a non-zero bitmap. A design that wrongly honoured the bitmap would move extra words.
- The empty list. A design that entered the transfer state would issue a stray access or stretch busy.
- A request raised in the middle of a transfer. A sequencer that accepted it would restart the address walk or write to the other base.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2
    } lsm_state_t;
endpackage

// File: rtl/lsm_pick_lowest.sv
module lsm_pick_lowest #(
    parameter int NREG  = 8,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  list,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [NREG-1:0]  rest
);
    always_comb begin
        any = |list;
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (list[i]) idx = IDX_W'(i);
        end
        rest = list & ~(NREG'(1) << idx);
    end

    // R2
    always_comb begin
        if (!$isunknown(list) && any) begin
            rest_shrink_chk: assert ($countones(rest) + 1 == $countones(list));
        end
    end
endmodule

// File: rtl/lsm_addr_step.sv
module lsm_addr_step #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= base;
        else if (step) addr <= addr + STRIDE;
    end
endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
    import lsm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NREG       = 8,
    parameter int WORD_BYTES = 4,
    parameter int IDX_W      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_multi,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [NREG-1:0]   req_list,
    input  logic [IDX_W-1:0]  req_reg,
    output logic              busy,
    output logic              done,
    output logic              fetch_stall,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

    lsm_state_t        state_q, state_d;
    logic [NREG-1:0]   list_q, list_d;
    logic              store_q, store_d;
    logic              done_q, done_d;
    logic              accept;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [NREG-1:0]   pick_rest;
    logic [ADDR_W-1:0] cur_addr;

    assign accept = (state_q == ST_IDLE) && req_valid;

    lsm_pick_lowest #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .list (list_q),
        .any  (pick_any),
        .idx  (pick_idx),
        .rest (pick_rest)
    );

    lsm_addr_step #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .base  (req_base),
        .step  (state_q == ST_XFER),
        .addr  (cur_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        list_d  = list_q;
        store_d = store_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_SETUP;
                    store_d = req_store;
                    list_d  = req_multi ? req_list : (NREG'(1) << req_reg);
                end
            end
            ST_SETUP: begin
                if (pick_any) begin
                    state_d = ST_XFER;
                end else begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_XFER: begin
                list_d = pick_rest;
                if (pick_rest == '0) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            list_q  <= '0;
            store_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            list_q  <= list_d;
            store_q <= store_d;
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        fetch_stall = busy;
        done        = done_q;
        mem_en      = (state_q == ST_XFER);
        mem_we      = mem_en && store_q;
        mem_addr    = cur_addr;
        mem_wdata   = rf_rdata;
        rf_raddr    = pick_idx;
        rf_we       = mem_en && !store_q;
        rf_waddr    = pick_idx;
        rf_wdata    = mem_rdata;
    end

    // R4
    addr_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && $past(mem_en) |-> mem_addr == $past(mem_addr) + STRIDE);

    // R5
    reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && $past(mem_en) |-> rf_raddr > $past(rf_raddr));

    // R9
    setup_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !mem_en);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_we != rf_we));
endmodule

// File: tb/lsm_sequencer_test.sv
module lsm_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_multi = 1'b0;
    logic [31:0] req_base = '0;
    logic [7:0]  req_list = '0;
    logic [2:0]  req_reg = '0;
    logic        busy, done, fetch_stall, mem_en, mem_we, rf_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic [2:0]  rf_raddr, rf_waddr;

    logic [31:0] mem [64];
    logic [31:0] rf  [8];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lsm_sequencer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_multi(req_multi), .req_base(req_base), .req_list(req_list), .req_reg(req_reg),
        .busy(busy), .done(done), .fetch_stall(fetch_stall), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata)
    );

    assign mem_rdata = mem[mem_addr[7:2]];
    assign rf_rdata  = rf[rf_raddr];

    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nth_set(input logic [7:0] l, input int k);
        int c = 0;
        for (int j = 0; j < 8; j++) begin
            if (l[j]) begin
                if (c == k) return j;
                c++;
            end
        end
        return -1;
    endfunction

    task automatic run_op(input logic st, input logic mu, input logic [31:0] base,
                          input logic [7:0] lst, input logic [2:0] rg, input bit poke);
        logic [31:0] rf_s [8];
        logic [31:0] mem_s [64];
        logic [7:0]  eff;
        int n, cyc, k;
        bit addr_ok, order_ok, stall_ok, setup_ok, done_low;
        for (int i = 0; i < 8; i++) rf_s[i] = rf[i];
        for (int i = 0; i < 64; i++) mem_s[i] = mem[i];
        eff = mu ? lst : (8'd1 << rg);
        n = $countones(eff);
        cyc = 0; k = 0;
        addr_ok = 1; order_ok = 1; stall_ok = 1; setup_ok = 1; done_low = 1;
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_multi = mu;
        req_base = base; req_list = lst; req_reg = rg;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && cyc < 40) begin
            cyc++;
            if (fetch_stall !== 1'b1) stall_ok = 0;
            if (done !== 1'b0) done_low = 0;
            if (cyc == 1 && mem_en) setup_ok = 0;
            if (mem_en) begin
                if (mem_addr !== base + 32'(4 * k)) addr_ok = 0;
                if (int'(rf_raddr) != nth_set(eff, k)) order_ok = 0;
                k++;
            end
            if (poke && cyc == 2) begin
                req_valid = 1'b1; req_store = 1'b1; req_multi = 1'b1;
                req_base = 32'hE0; req_list = 8'hFF;
            end
            if (poke && cyc == 3) req_valid = 1'b0;
            @(negedge clk);
        end
        chk(cyc == 1 + n, mu ? "R2 busy cycles" : "R3 busy cycles", cyc, 1 + n);
        chk(k == n && setup_ok, "R4 access count", k, n);
        chk(addr_ok, "R4 address walk", 0, 1);
        chk(order_ok, "R5 register order", 0, 1);
        chk(stall_ok && fetch_stall === 1'b0, "R8 fetch stall", fetch_stall, 0);
        chk(done === 1'b1 && done_low, "R10 done after last", done, 1);
        for (int q = 0; q < n; q++) begin
            int j = nth_set(eff, q);
            int w = int'(base[7:2]) + q;
            if (st) chk(mem[w] === rf_s[j], "R7 store data", mem[w], rf_s[j]);
            else    chk(rf[j] === mem_s[w], "R6 load data", rf[j], mem_s[w]);
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10 done one cycle", done, 0);
        if (n == 0) begin
            for (int j = 0; j < 8; j++) chk(rf[j] === rf_s[j], "R9 no reg write", rf[j], rf_s[j]);
        end
        if (poke) begin
            repeat (3) begin
                chk(busy === 1'b0, "R11 busy request ignored", busy, 0);
                @(negedge clk);
            end
            for (int w = 56; w < 64; w++) chk(mem[w] === mem_s[w], "R11 memory untouched", mem[w], mem_s[w]);
        end
    endtask

    // {store, multi, base[7:0], list[7:0], reg[2:0]}
    localparam logic [20:0] VEC [6] = '{
        {1'b0, 1'b1, 8'h10, 8'hFF, 3'd0},
        {1'b1, 1'b1, 8'h40, 8'hA5, 3'd0},
        {1'b0, 1'b1, 8'h80, 8'h01, 3'd0},
        {1'b1, 1'b1, 8'h20, 8'h80, 3'd0},
        {1'b0, 1'b0, 8'h60, 8'h0F, 3'd5},
        {1'b1, 1'b0, 8'hC0, 8'hF0, 3'd2}
    };

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h5000_0000 + 32'(i * 3);
        for (int i = 0; i < 8; i++)  rf[i]  = 32'hA000_0000 + 32'(i);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy === 0 && done === 0 && fetch_stall === 0, "R1 reset status", {busy, done, fetch_stall}, 0);
        chk(mem_en === 0 && mem_we === 0 && rf_we === 0, "R1 reset bus", {mem_en, mem_we, rf_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < 6; v++) begin
            run_op(VEC[v][20], VEC[v][19], {24'd0, VEC[v][18:11]}, VEC[v][10:3], VEC[v][2:0], 1'b0);
        end
        // R9 empty list
        run_op(1'b0, 1'b1, 32'h30, 8'h00, 3'd0, 1'b0);
        // R11 request while busy
        run_op(1'b1, 1'b1, 32'h00, 8'h06, 3'd0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule